// File: doc/BRIEF.md
# Addressed Serial Node Command Decoder

This block sits behind the byte interface of a UART on one node of a multi-drop, half-duplex differential field bus running at 345 kbaud. It assembles incoming bytes into frames, checks the closing CRC byte and keeps track of whether the node is currently addressed. It executes channel and configuration-parameter reads and writes against two internal banks of 256 bytes each. Replies and optional acknowledges are handed back to the UART as a two-byte sequence: a data byte followed by its CRC.

Each frame opens with a command byte. Bits 7:4 hold the opcode, bit 3 requests an acknowledge and bits 2:0 give the number of payload bytes between the command byte and the CRC. An address frame carries the 16-bit node address, high byte first. A node that sees its own address becomes selected and stays selected until an address frame names a different node. While deselected it acts only on address frames. If the line falls silent for more than ten byte times in the middle of a frame, the parser drops the partial frame and takes the next byte as a new command byte.

Top module: `node_cmd_decoder`

## Requirements
- R1: The CRC is CRC-8 with polynomial 0x31 (x^8+x^5+x^4+1), initial value 0x00, shifted in MSB first. It covers every byte of the frame before the CRC byte. A frame whose CRC byte does not match is discarded: nothing is written and nothing is sent.
- R2: An address frame (opcode 0x0, length 2, payload = address MSB then LSB) selects the node when the address equals `node_id` and deselects it otherwise. The selection changes only after a frame with a correct CRC.
- R3: While the node is deselected, read and write frames produce no reply and change no bank entry.
- R4: A channel write (opcode 0x1, length 2, payload = channel, value) stores the value in that channel.
- R5: A channel read (opcode 0x2, length 1, payload = channel) replies with the stored byte followed by the CRC of that byte.
- R6: Parameter write (opcode 0x3, length 2) and parameter read (opcode 0x4, length 1) behave like R4 and R5 on a bank that is separate from the channels.
- R7: When bit 3 of the command byte is set, a matching address frame or an executed write replies with 0x78 followed by its CRC. When bit 3 is clear, neither sends anything.
- R8: A frame whose length field does not match its opcode is still parsed to its end using that length, but it is not executed.
- R9: If more than 10 byte times pass without a byte while a frame is incomplete, the partial frame is dropped and the next byte is parsed as a command byte.
- R10: After reset the node is deselected, every channel and parameter reads 0x00, and `tx_valid` is low.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_byte` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | 16 | Address of this node |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | The UART accepts the byte currently offered |
| tx_valid | output | 1 | A reply byte is offered |
| tx_byte | output | 8 | Reply byte |

## Verification
The checker watches four behaviours on every cycle. The transmit byte holds steady under backpressure. Selection changes only right after a frame that passed its CRC check. A frame with a bad CRC, or a read or write arriving while the node is deselected, never leads to a reply. The parser always returns to the command state once the line has been silent past the gap limit. The values actually stored, the separation of the channel bank from the parameter bank, the reply and acknowledge CRCs, the rejection of frames with a wrong length, and the effect of a timeout on the byte that follows it can only be shown by the bench's frame sequences, which compare each transmitted byte with a queue of expected replies.

// File: rtl/node_bus_pkg.sv
package node_bus_pkg;

    localparam int BYTE_W    = 8;
    localparam int NODE_ID_W = 16;
    localparam int NBANK     = 2;
    localparam int BK_CH     = 0;
    localparam int BK_PAR    = 1;

    localparam logic [3:0] OP_ADDR   = 4'h0;
    localparam logic [3:0] OP_WR_CH  = 4'h1;
    localparam logic [3:0] OP_RD_CH  = 4'h2;
    localparam logic [3:0] OP_WR_PAR = 4'h3;
    localparam logic [3:0] OP_RD_PAR = 4'h4;

    localparam logic [BYTE_W-1:0] ACK_CODE = 8'h78;
    localparam logic [BYTE_W-1:0] CRC_POLY = 8'h31;

    typedef struct packed {
        logic [3:0] op;
        logic       ack;
        logic [2:0] len;
    } cmd_t;

    typedef struct packed {
        cmd_t              cmd;
        logic [BYTE_W-1:0] p0;
        logic [BYTE_W-1:0] p1;
    } frame_t;

    function automatic logic [BYTE_W-1:0] crc8_step(input logic [BYTE_W-1:0] crc,
                                                    input logic [BYTE_W-1:0] d);
        logic [BYTE_W-1:0] c;
        logic              fb;
        c = crc;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = c[BYTE_W-1] ^ d[i];
            c  = {c[BYTE_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/node_frame_parser.sv
module node_frame_parser
    import node_bus_pkg::*;
#(
    parameter int GAP_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              frm_done,
    output logic              frm_ok,
    output frame_t            frm,
    output logic              busy
);
    localparam int GW = $clog2(GAP_CYC + 1);

    typedef enum logic [1:0] {S_CMD, S_PAY, S_CRC} pst_e;

    pst_e              st;
    logic [2:0]        rem;
    logic [2:0]        idx;
    logic [BYTE_W-1:0] crc_r;
    logic [GW-1:0]     gap;

    assign busy = (st != S_CMD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_CMD;
            rem      <= '0;
            idx      <= '0;
            crc_r    <= '0;
            gap      <= '0;
            frm_done <= 1'b0;
            frm_ok   <= 1'b0;
            frm      <= '0;
        end else begin
            frm_done <= 1'b0;
            if (rx_valid) begin
                gap <= '0;
                case (st)
                    S_CMD: begin
                        frm.cmd <= cmd_t'(rx_byte);
                        crc_r   <= crc8_step('0, rx_byte);
                        rem     <= rx_byte[2:0];
                        idx     <= '0;
                        st      <= (rx_byte[2:0] == 3'd0) ? S_CRC : S_PAY;
                    end
                    S_PAY: begin
                        if (idx == 3'd0) frm.p0 <= rx_byte;
                        if (idx == 3'd1) frm.p1 <= rx_byte;
                        idx   <= idx + 3'd1;
                        rem   <= rem - 3'd1;
                        crc_r <= crc8_step(crc_r, rx_byte);
                        if (rem == 3'd1) st <= S_CRC;
                    end
                    default: begin
                        frm_done <= 1'b1;
                        frm_ok   <= (rx_byte == crc_r);
                        st       <= S_CMD;
                    end
                endcase
            end else if (st != S_CMD) begin
                if (gap == GW'(GAP_CYC - 1)) begin
                    st  <= S_CMD;
                    gap <= '0;
                end else begin
                    gap <= gap + 1'b1;
                end
            end else begin
                gap <= '0;
            end
        end
    end
endmodule

// File: rtl/node_reg_bank.sv
module node_reg_bank
    import node_bus_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr[AW-1:0]] <= wdata;
        end
    end

    assign rdata = mem[addr[AW-1:0]];
endmodule

// File: rtl/node_cmd_exec.sv
module node_cmd_exec
    import node_bus_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NODE_ID_W-1:0]         node_id,
    input  logic                         frm_done,
    input  logic                         frm_ok,
    input  frame_t                       frm,
    input  logic [NBANK-1:0][BYTE_W-1:0] bank_rdata,
    output logic [NBANK-1:0]             bank_we,
    output logic                         selected,
    output logic                         rep_valid,
    output logic [BYTE_W-1:0]            rep_byte
);
    logic go, wr_hit, rd_hit, addr_hit, id_match;
    logic bsel;

    assign go       = frm_done && frm_ok;
    assign id_match = ({frm.p0, frm.p1} == node_id);
    assign addr_hit = (frm.cmd.op == OP_ADDR) && (frm.cmd.len == 3'd2);

    always_comb begin
        wr_hit  = 1'b0;
        rd_hit  = 1'b0;
        bsel    = 1'b0;
        bank_we = '0;
        case (frm.cmd.op)
            OP_WR_CH:  begin bsel = 1'(BK_CH);  wr_hit = (frm.cmd.len == 3'd2); end
            OP_WR_PAR: begin bsel = 1'(BK_PAR); wr_hit = (frm.cmd.len == 3'd2); end
            OP_RD_CH:  begin bsel = 1'(BK_CH);  rd_hit = (frm.cmd.len == 3'd1); end
            OP_RD_PAR: begin bsel = 1'(BK_PAR); rd_hit = (frm.cmd.len == 3'd1); end
            default: ;
        endcase
        if (go && selected && wr_hit) bank_we[bsel] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            selected  <= 1'b0;
            rep_valid <= 1'b0;
            rep_byte  <= '0;
        end else begin
            rep_valid <= 1'b0;
            if (go) begin
                if (addr_hit) begin
                    selected <= id_match;
                    if (id_match && frm.cmd.ack) begin
                        rep_valid <= 1'b1;
                        rep_byte  <= ACK_CODE;
                    end
                end else if (selected && wr_hit && frm.cmd.ack) begin
                    rep_valid <= 1'b1;
                    rep_byte  <= ACK_CODE;
                end else if (selected && rd_hit) begin
                    rep_valid <= 1'b1;
                    rep_byte  <= bank_rdata[bsel];
                end
            end
        end
    end
endmodule

// File: rtl/node_reply_tx.sv
module node_reply_tx
    import node_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rep_valid,
    input  logic [BYTE_W-1:0] rep_byte,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte
);
    typedef enum logic [1:0] {T_IDLE, T_DATA, T_CRC} tst_e;

    tst_e              st;
    logic [BYTE_W-1:0] data_r;
    logic [BYTE_W-1:0] crc_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= T_IDLE;
            data_r <= '0;
            crc_r  <= '0;
        end else begin
            case (st)
                T_IDLE: if (rep_valid) begin
                    data_r <= rep_byte;
                    crc_r  <= crc8_step('0, rep_byte);
                    st     <= T_DATA;
                end
                T_DATA: if (tx_ready) st <= T_CRC;
                default: if (tx_ready) st <= T_IDLE;
            endcase
        end
    end

    assign tx_valid = (st != T_IDLE);
    assign tx_byte  = (st == T_CRC) ? crc_r : data_r;
endmodule

// File: rtl/node_cmd_decoder.sv
module node_cmd_decoder
    import node_bus_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int BAUD   = 345_000,
    parameter int N_CH   = 256,
    parameter int N_PAR  = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NODE_ID_W-1:0] node_id,
    input  logic                 rx_valid,
    input  logic [BYTE_W-1:0]    rx_byte,
    input  logic                 tx_ready,
    output logic                 tx_valid,
    output logic [BYTE_W-1:0]    tx_byte
);
    localparam int BIT_CYC  = CLK_HZ / BAUD;
    localparam int BYTE_CYC = BIT_CYC * 10;
    localparam int GAP_CYC  = BYTE_CYC * 10;

    frame_t                       frm;
    logic                         frm_done, frm_ok, parse_busy;
    logic [3:0]                   frm_op;
    logic [NBANK-1:0]             bank_we;
    logic [NBANK-1:0][BYTE_W-1:0] bank_rdata;
    logic                         selected, rep_valid;
    logic [BYTE_W-1:0]            rep_byte;

    assign frm_op = frm.cmd.op;

    node_frame_parser #(.GAP_CYC(GAP_CYC)) u_parser (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .frm_done(frm_done), .frm_ok(frm_ok), .frm(frm), .busy(parse_busy)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam int D = (g == BK_CH) ? N_CH : N_PAR;
        node_reg_bank #(.DEPTH(D)) u_bank (
            .clk(clk), .rst(rst), .we(bank_we[g]), .addr(frm.p0),
            .wdata(frm.p1), .rdata(bank_rdata[g])
        );
    end

    node_cmd_exec u_exec (
        .clk(clk), .rst(rst), .node_id(node_id), .frm_done(frm_done),
        .frm_ok(frm_ok), .frm(frm), .bank_rdata(bank_rdata), .bank_we(bank_we),
        .selected(selected), .rep_valid(rep_valid), .rep_byte(rep_byte)
    );

    node_reply_tx u_tx (
        .clk(clk), .rst(rst), .rep_valid(rep_valid), .rep_byte(rep_byte),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte)
    );
endmodule

// File: rtl/node_cmd_checker.sv
module node_cmd_checker
    import node_bus_pkg::*;
#(
    parameter int GAP_CYC = 1000
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              busy,
    input logic              frm_done,
    input logic              frm_ok,
    input logic [3:0]        frm_op,
    input logic              selected,
    input logic              rep_valid
);
    localparam int QW = $clog2(GAP_CYC + 3);

    logic [QW-1:0] quiet;

    always_ff @(posedge clk) begin
        if (rst || rx_valid) quiet <= '0;
        else if (quiet != QW'(GAP_CYC + 2)) quiet <= quiet + 1'b1;
    end

    assert_badcrc_silent_R1: assert property (@(posedge clk) disable iff (rst)
        (frm_done && !frm_ok) |=> !rep_valid);

    assert_sel_after_good_frame_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(selected) |-> $past(frm_done && frm_ok));

    assert_unselected_silent_R3: assert property (@(posedge clk) disable iff (rst)
        (frm_done && frm_ok && !selected && frm_op != OP_ADDR) |=> !rep_valid);

    assert_gap_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (quiet > QW'(GAP_CYC)) |-> !busy);

    assert_tx_idle_after_reset_R10: assert property (@(posedge clk)
        $fell(rst) |-> !tx_valid);

    assert_tx_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));
endmodule

bind node_cmd_decoder node_cmd_checker #(.GAP_CYC(GAP_CYC)) u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_byte(tx_byte), .busy(parse_busy),
    .frm_done(frm_done), .frm_ok(frm_ok), .frm_op(frm_op),
    .selected(selected), .rep_valid(rep_valid)
);

// File: tb/tb_node_cmd_decoder.sv
module tb_node_cmd_decoder;
    localparam logic [15:0] MY_ID = 16'hA5C3;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic       tx_ready;
    logic       tx_valid;
    logic [7:0] tx_byte;

    always #5 clk = ~clk;

    node_cmd_decoder #(.CLK_HZ(3_450_000), .BAUD(345_000)) dut (
        .clk(clk), .rst(rst), .node_id(MY_ID), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_ready(tx_ready), .tx_valid(tx_valid),
        .tx_byte(tx_byte)
    );

    logic [7:0] exp_q[$];
    string      tag_q[$];
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 0;

    function automatic logic [7:0] crc_add(input logic [7:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = {c ^ d, 8'h00};
        for (int i = 15; i >= 8; i--)
            if (r[i]) r = r ^ (16'h0131 << (i - 8));
        return r[7:0];
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [7:0] b);
        step();
        rx_valid = 1'b1;
        rx_byte  = b;
        step();
        rx_valid = 1'b0;
    endtask

    task automatic frame(input logic [7:0] cmd, input logic [7:0] a,
                         input logic [7:0] b, input bit bad);
        logic [7:0] c;
        c = crc_add(8'h00, cmd);
        send(cmd);
        for (int i = 0; i < int'(cmd[2:0]); i++) begin
            logic [7:0] v;
            v = (i == 0) ? a : ((i == 1) ? b : 8'h00);
            c = crc_add(c, v);
            send(v);
        end
        send(bad ? (c ^ 8'h01) : c);
        repeat (20) step();
    endtask

    task automatic expect_reply(input logic [7:0] d, input string tag);
        exp_q.push_back(d);
        tag_q.push_back(tag);
        exp_q.push_back(crc_add(8'h00, d));
        tag_q.push_back({tag, " crc"});
    endtask

    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R3 unexpected reply byte: actual %02h expected none", tx_byte);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (tx_byte !== e) begin
                    fails++;
                    $display("FAIL %s: actual %02h expected %02h", t, tx_byte, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst      = 1'b1;
        rx_valid = 1'b0;
        rx_byte  = 8'h00;
        tx_ready = 1'b1;
        repeat (4) step();
        rst = 1'b0;
        step();

        checks++;
        if (tx_valid !== 1'b0) begin
            fails++;
            $display("FAIL R10 tx_valid after reset: actual %b expected 0", tx_valid);
        end

        // R3: deselected node ignores a read
        frame(8'h21, 8'h05, 8'h00, 0);
        // R2, R7: address with ack selects the node
        expect_reply(8'h78, "R7 address ack");
        frame(8'h0A, MY_ID[15:8], MY_ID[7:0], 0);
        // R10: banks start at zero
        expect_reply(8'h00, "R10 channel reset value");
        frame(8'h21, 8'h05, 8'h00, 0);
        expect_reply(8'h00, "R10 param reset value");
        frame(8'h41, 8'hFF, 8'h00, 0);
        // R4, R6, R7: writes, with and without ack
        frame(8'h12, 8'h05, 8'h3C, 0);
        expect_reply(8'h78, "R7 param write ack");
        frame(8'h3A, 8'h05, 8'hD2, 0);
        frame(8'h12, 8'hFF, 8'hE1, 0);
        frame(8'h12, 8'h00, 8'h5A, 0);
        frame(8'h12, 8'hC8, 8'h44, 0);
        expect_reply(8'h3C, "R4 read channel 5");
        frame(8'h21, 8'h05, 8'h00, 0);
        expect_reply(8'hD2, "R6 read param 5");
        frame(8'h41, 8'h05, 8'h00, 0);
        expect_reply(8'hE1, "R4 read channel 255");
        frame(8'h21, 8'hFF, 8'h00, 0);
        expect_reply(8'h5A, "R5 read channel 0");
        frame(8'h21, 8'h00, 8'h00, 0);
        expect_reply(8'h00, "R6 param bank separate");
        frame(8'h41, 8'hFF, 8'h00, 0);
        // R1: bad CRC write is dropped
        frame(8'h1A, 8'h05, 8'h11, 1);
        expect_reply(8'h3C, "R1 bad crc write dropped");
        frame(8'h21, 8'h05, 8'h00, 0);
        // R8: length mismatch not executed
        frame(8'h13, 8'h05, 8'h77, 0);
        frame(8'h22, 8'h05, 8'h00, 0);
        expect_reply(8'h3C, "R8 wrong-length write ignored");
        frame(8'h21, 8'h05, 8'h00, 0);
        // R2, R3: other address deselects, writes then ignored
        frame(8'h0A, 8'h12, 8'h34, 0);
        frame(8'h1A, 8'h05, 8'h99, 0);
        frame(8'h3A, 8'h05, 8'h99, 0);
        expect_reply(8'h78, "R2 reselect ack");
        frame(8'h0A, MY_ID[15:8], MY_ID[7:0], 0);
        expect_reply(8'h3C, "R3 deselected channel write ignored");
        frame(8'h21, 8'h05, 8'h00, 0);
        expect_reply(8'hD2, "R3 deselected param write ignored");
        frame(8'h41, 8'h05, 8'h00, 0);
        // R9: partial frame, long gap, then a fresh read
        send(8'h12);
        send(8'hC8);
        repeat (1100) step();
        expect_reply(8'h44, "R9 gap restart read");
        frame(8'h21, 8'hC8, 8'h00, 0);
        // R11: backpressure holds the byte
        tx_ready = 1'b0;
        frame(8'h41, 8'h05, 8'h00, 0);
        repeat (10) step();
        checks++;
        if (tx_valid !== 1'b1 || tx_byte !== 8'hD2) begin
            fails++;
            $display("FAIL R11 held byte: actual %b/%02h expected 1/d2", tx_valid, tx_byte);
        end
        expect_reply(8'hD2, "R11 released byte");
        tx_ready = 1'b1;
        repeat (20) step();

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R5 missing replies: actual %0d pending expected 0", exp_q.size());
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule